// File: doc/BRIEF.md
# DMA Sample Counter with Terminal Interrupt

This block tracks how many samples remain in a host buffer that a DMA engine is filling or draining. Software programs a 16-bit base value as two bytes. The low byte is held until the high byte is written, and that write loads the whole value into the running counter. While DMA counting is active, each per-sample completion strobe from the transfer side moves the counter one step down. The sample that arrives once the counter already shows zero is the end of the buffer. On that sample the block raises an interrupt and restarts the count from the stored base value.

Counting is active only when the enable bit is set and the PIO-select bit is clear. The PIO-select bit is guarded: a control write can change it only while the mode-change-enable input is high. The enable bit is taken on every control write. The interrupt stays set until the host clears it. The block does not perform the bus transfers and holds no FIFO.

Top module: `dma_sample_counter`

## Requirements
- R1: A write strobe on the upper base byte loads the current count with the written byte in bits 15:8 and the held lower base byte in bits 7:0. The new value is visible after the next clock edge.
- R2: A write to the lower base byte alone leaves the current count unchanged.
- R3: A control write always updates the enable bit. It updates the PIO-select bit only when mode-change-enable is high in that cycle. Otherwise the PIO-select bit keeps its value.
- R4: The DMA-enabled output is high exactly when enable is 1 and PIO-select is 0. A sample strobe in a cycle where DMA is enabled and the count is non-zero decrements the count by one. A sample strobe while DMA is disabled changes nothing.
- R5: A sample strobe in a cycle where DMA is enabled and the count is zero sets the interrupt. In the same cycle it reloads the count from the two base bytes.
- R6: The interrupt stays high until an interrupt-clear strobe arrives. If a terminal sample and a clear arrive in the same cycle, the interrupt stays set.
- R7: If an upper base write and an enabled sample strobe arrive in the same cycle, the base load takes effect and the count does not also decrement.
- R8: While reset is low, the base bytes, count, enable, PIO-select and interrupt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrData | input | 8 | Write data for base bytes |
| baseLoWe | input | 1 | Lower base byte write strobe |
| baseHiWe | input | 1 | Upper base byte write strobe (loads count) |
| ctrlWe | input | 1 | Control write strobe |
| ctrlEnIn | input | 1 | Enable value for a control write |
| ctrlPioIn | input | 1 | PIO-select value for a control write |
| modeChgEn | input | 1 | Mode-change-enable; permits PIO-select update |
| sampleDone | input | 1 | One-cycle strobe per transferred sample |
| irqClr | input | 1 | Interrupt clear strobe |
| curCount | output | 16 | Current count readback |
| dmaActive | output | 1 | DMA counting enabled |
| irqFlag | output | 1 | Sticky terminal-count interrupt |

## Verification
The counter is visible on the ports in every cycle. A wrong load, a wrong decrement or a missed reload therefore shows on curCount one edge after the offending strobe. An interrupt that is raised one sample early or one sample late shows as a one-cycle skew between irqFlag and the zero-to-base transition of curCount. A PIO-select bit changed without permission shows at once on dmaActive. It shows again on the next sample, which then fails to move the count.

// File: rtl/dmacnt_pkg.sv
package dmacnt_pkg;
  typedef struct packed {
    logic loadCount;
    logic decCount;
    logic reloadCount;
    logic setIrq;
  } cntStrobes_t;
endpackage

// File: rtl/dmacnt_datapath.sv
module dmacnt_datapath
  import dmacnt_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int COUNT_W = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baseLoWe,
  input  logic [BYTE_W-1:0]  wrData,
  input  cntStrobes_t        strobes,
  output logic [COUNT_W-1:0] curCount,
  output logic               countZero
);
  logic [BYTE_W-1:0] baseLo;
  logic [BYTE_W-1:0] baseHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseLo   <= '0;
      baseHi   <= '0;
      curCount <= '0;
    end else begin
      if (baseLoWe) baseLo <= wrData;
      if (strobes.loadCount) begin
        baseHi   <= wrData;
        curCount <= {wrData, baseLo};
      end else if (strobes.reloadCount) begin
        curCount <= {baseHi, baseLo};
      end else if (strobes.decCount) begin
        curCount <= curCount - 1'b1;
      end
    end
  end

  assign countZero = (curCount == '0);

  AST_LOAD_FROM_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCount |=> curCount == {$past(wrData), $past(baseLo)}); // R1
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadCount || strobes.reloadCount || strobes.decCount) |=> $stable(curCount)); // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    strobes.decCount |=> curCount == $past(curCount) - 1'b1); // R4
  AST_RELOAD_BASE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reloadCount |=> curCount == {baseHi, baseLo}); // R5
endmodule

// File: rtl/dmacnt_ctrl.sv
module dmacnt_ctrl
  import dmacnt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        baseHiWe,
  input  logic        ctrlWe,
  input  logic        ctrlEnIn,
  input  logic        ctrlPioIn,
  input  logic        modeChgEn,
  input  logic        sampleDone,
  input  logic        irqClr,
  input  logic        countZero,
  output cntStrobes_t strobes,
  output logic        dmaActive,
  output logic        irqFlag
);
  logic enableBit;
  logic pioSel;
  logic activeSample;
  logic terminal;

  assign dmaActive    = enableBit && !pioSel;
  assign activeSample = sampleDone && dmaActive;
  assign terminal     = activeSample && countZero;

  always_comb begin
    strobes             = '0;
    strobes.loadCount   = baseHiWe;
    strobes.reloadCount = terminal && !baseHiWe;
    strobes.decCount    = activeSample && !countZero && !baseHiWe;
    strobes.setIrq      = terminal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableBit <= 1'b0;
      pioSel    <= 1'b0;
      irqFlag   <= 1'b0;
    end else begin
      if (ctrlWe) begin
        enableBit <= ctrlEnIn;
        if (modeChgEn) pioSel <= ctrlPioIn;
      end
      if (strobes.setIrq)  irqFlag <= 1'b1;
      else if (irqClr)     irqFlag <= 1'b0;
    end
  end

  AST_PIO_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !modeChgEn |=> $stable(pioSel)); // R3
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !irqClr |=> irqFlag); // R6
  AST_TERMINAL_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    sampleDone && dmaActive && countZero |=> irqFlag); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadCount, strobes.reloadCount, strobes.decCount})); // R7
endmodule

// File: rtl/dma_sample_counter.sv
module dma_sample_counter
  import dmacnt_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int COUNT_W = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BYTE_W-1:0]  wrData,
  input  logic               baseLoWe,
  input  logic               baseHiWe,
  input  logic               ctrlWe,
  input  logic               ctrlEnIn,
  input  logic               ctrlPioIn,
  input  logic               modeChgEn,
  input  logic               sampleDone,
  input  logic               irqClr,
  output logic [COUNT_W-1:0] curCount,
  output logic               dmaActive,
  output logic               irqFlag
);
  cntStrobes_t strobes;
  logic        countZero;

  dmacnt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .baseHiWe(baseHiWe), .ctrlWe(ctrlWe),
    .ctrlEnIn(ctrlEnIn), .ctrlPioIn(ctrlPioIn), .modeChgEn(modeChgEn),
    .sampleDone(sampleDone), .irqClr(irqClr), .countZero(countZero),
    .strobes(strobes), .dmaActive(dmaActive), .irqFlag(irqFlag)
  );

  dmacnt_datapath #(.BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .baseLoWe(baseLoWe), .wrData(wrData),
    .strobes(strobes), .curCount(curCount), .countZero(countZero)
  );

  AST_INACTIVE_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    !dmaActive && !baseHiWe |=> $stable(curCount)); // R4
endmodule

// File: tb/dma_sample_counter_tb_top.sv
module dma_sample_counter_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  wrData;
  logic        baseLoWe, baseHiWe, ctrlWe, ctrlEnIn, ctrlPioIn, modeChgEn;
  logic        sampleDone, irqClr;
  logic [15:0] curCount;
  logic        dmaActive, irqFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_sample_counter dut_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .baseLoWe(baseLoWe),
    .baseHiWe(baseHiWe), .ctrlWe(ctrlWe), .ctrlEnIn(ctrlEnIn),
    .ctrlPioIn(ctrlPioIn), .modeChgEn(modeChgEn), .sampleDone(sampleDone),
    .irqClr(irqClr), .curCount(curCount), .dmaActive(dmaActive), .irqFlag(irqFlag)
  );

  localparam logic [2:0] OP_NOP = 3'd0, OP_WLO = 3'd1, OP_WHI = 3'd2,
                         OP_CTRL = 3'd3, OP_SAMP = 3'd4, OP_CLR = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  data;
    logic        en;
    logic        pio;
    logic        mce;
    logic [15:0] expCount;
    logic        expIrq;
    logic        expActive;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{OP_WLO,  8'h03, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0}, // R2
    '{OP_WHI,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0003, 1'b0, 1'b0}, // R1
    '{OP_SAMP, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0003, 1'b0, 1'b0}, // R4 inactive
    '{OP_CTRL, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0003, 1'b0, 1'b1}, // R3 enable
    '{OP_SAMP, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0002, 1'b0, 1'b1}, // R4
    '{OP_SAMP, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b1},
    '{OP_NOP,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b1},
    '{OP_SAMP, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1}, // R5 at zero, no irq yet
    '{OP_SAMP, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0003, 1'b1, 1'b1}, // R5 reload + irq
    '{OP_SAMP, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0002, 1'b1, 1'b1}, // R6 sticky
    '{OP_CLR,  8'h00, 1'b0, 1'b0, 1'b0, 16'h0002, 1'b0, 1'b1}, // R6 clear
    '{OP_CTRL, 8'h00, 1'b1, 1'b1, 1'b0, 16'h0002, 1'b0, 1'b1}, // R3 pio ignored
    '{OP_SAMP, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b1},
    '{OP_CTRL, 8'h00, 1'b1, 1'b1, 1'b1, 16'h0001, 1'b0, 1'b0}, // R3 pio taken
    '{OP_SAMP, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b0}, // R4 pio mode
    '{OP_CTRL, 8'h00, 1'b1, 1'b0, 1'b1, 16'h0001, 1'b0, 1'b1},
    '{OP_WLO,  8'h34, 1'b0, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b1}, // R2
    '{OP_WHI,  8'h12, 1'b0, 1'b0, 1'b0, 16'h1234, 1'b0, 1'b1}, // R1
    '{OP_SAMP, 8'h00, 1'b0, 1'b0, 1'b0, 16'h1233, 1'b0, 1'b1},
    '{OP_CTRL, 8'h00, 1'b0, 1'b0, 1'b0, 16'h1233, 1'b0, 1'b0}, // R4 disabled
    '{OP_SAMP, 8'h00, 1'b0, 1'b0, 1'b0, 16'h1233, 1'b0, 1'b0}
  };

  task automatic idleInputs();
    wrData = '0; baseLoWe = 0; baseHiWe = 0; ctrlWe = 0; ctrlEnIn = 0;
    ctrlPioIn = 0; modeChgEn = 0; sampleDone = 0; irqClr = 0;
  endtask

  task automatic check(string tag, logic [15:0] eCnt, logic eIrq, logic eAct);
    checks++;
    if (curCount !== eCnt || irqFlag !== eIrq || dmaActive !== eAct) begin
      failures++;
      $display("FAIL %s: count=%h irq=%b act=%b expected count=%h irq=%b act=%b",
               tag, curCount, irqFlag, dmaActive, eCnt, eIrq, eAct);
    end
  endtask

  task automatic applyOp(vec_t v);
    idleInputs();
    wrData = v.data;
    case (v.op)
      OP_WLO:  baseLoWe = 1;
      OP_WHI:  baseHiWe = 1;
      OP_CTRL: begin ctrlWe = 1; ctrlEnIn = v.en; ctrlPioIn = v.pio; modeChgEn = v.mce; end
      OP_SAMP: sampleDone = 1;
      OP_CLR:  irqClr = 1;
      default: ;
    endcase
    @(negedge clk);
    idleInputs();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idleInputs();
    rstN = 0;
    repeat (3) @(negedge clk);
    check("R8 reset state", 16'h0000, 1'b0, 1'b0);
    rstN = 1;

    for (int i = 0; i < NVEC; i++) begin
      applyOp(VECS[i]);
      check($sformatf("R1 R2 R3 R4 R5 R6 table step %0d", i),
            VECS[i].expCount, VECS[i].expIrq, VECS[i].expActive);
    end

    // Reset mid-run: R8
    rstN = 0; @(negedge clk);
    check("R8 reset clears", 16'h0000, 1'b0, 1'b0);
    rstN = 1;

    // Base of 1, enable, reach zero
    applyOp('{OP_WLO, 8'h01, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0});
    applyOp('{OP_WHI, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0});
    applyOp('{OP_CTRL, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0});
    applyOp('{OP_SAMP, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0});
    check("R4 count to zero", 16'h0000, 1'b0, 1'b1);

    // R6: terminal sample and clear together -> set wins
    sampleDone = 1; irqClr = 1;
    @(negedge clk); idleInputs();
    check("R6 set beats clear", 16'h0001, 1'b1, 1'b1);

    // R7: upper write and active sample together -> load wins
    wrData = 8'h05; baseHiWe = 1; sampleDone = 1;
    @(negedge clk); idleInputs();
    check("R7 load beats decrement", 16'h0501, 1'b1, 1'b1);

    // R6: clear alone drops the flag
    irqClr = 1;
    @(negedge clk); idleInputs();
    check("R6 clear", 16'h0501, 1'b0, 1'b1);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule